// File: doc/BRIEF.md
# SPI Slave Register Bridge

This block lets an external host reach a simple internal register bus over a four-wire SPI link. The host sends a 32-bit command word, and then a burst of 32-bit data words inside the same chip-select frame. The command word carries a register byte address, an operation code, an address-step flag and a word count. Each write data word turns into one single-cycle write strobe on the register bus. For a read burst, the block fetches each register ahead of time, and the host clocks the value out on MISO during the following 32-bit frame.

The SPI pins are asynchronous to the system clock. They pass through flop synchronisers, and SCLK edges are detected in the system clock domain. SPI mode 0 is used: the block samples on the rising SCLK edge and changes MISO after the falling edge. All words go most significant bit first. A burst can be cut short in two ways. Raising chip select drops it at once. An inter-edge gap longer than a programmable number of system clocks also drops it. In both cases the next complete word is treated as a command.

Top module: `spib_bridge`

## Requirements
- R1: The command word is laid out as follows: bits 31..16 hold the byte address, bits 15..12 the operation (4'hA read, 4'hB write), bit 11 the step flag and bits 10..4 the count. Bits 3..0 are ignored. Every word is shifted MSB first in SPI mode 0.
- R2: In a write burst, each completed data word produces exactly one `bus_wr` pulse, with that word on `bus_wdata` and the current address on `bus_addr`.
- R3: With the step flag set, the access address grows by 4 after every data word. With the flag clear, every word of the burst uses the command address.
- R4: In a read burst, the block raises `bus_rd` for the first address once the command word is complete. It takes `bus_rdata` in the cycle after `bus_rd`, and that value is shifted out MSB first on `spi_miso` during the next frame. Each further word of the burst is fetched after the previous data word completes.
- R5: A count of N words takes N data words, and a count of 0 takes one. The word after the last data word is decoded as a new command.
- R6: A command word with any other operation code causes no bus access, and the next word is decoded as a command.
- R7: Inside a burst, if no rising SCLK edge arrives for `burst_timeout` system clocks, the burst is abandoned, any partial word is dropped, and the next word is a command. A value of 0 turns the timeout off.
- R8: While `spi_cs_n` is high, the block returns to command wait, discards any partial word, makes no bus access and holds `spi_miso` low.
- R9: After reset, `spi_miso`, `bus_wr` and `bus_rd` are low.
- R10: `bus_wr` and `bus_rd` are never high together, and each is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| burst_timeout | input | TO_W | Maximum gap in system clocks between rising SCLK edges inside a burst, 0 = off |
| bus_addr | output | 16 | Register byte address |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_wdata | output | 32 | Write data |
| bus_rd | output | 1 | Single-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid in the cycle after `bus_rd` |

## Verification
The assertions assume that each SCLK phase lasts long enough for a synchronised edge to be seen before the next edge arrives: at least eight system clocks, which also covers the read fetch before the next rising edge. They also assume that chip select changes only while SCLK is low and at least half a period after the last rising edge, so that no word completes at the moment the frame closes. The stimulus drives SCLK with a ten-cycle half period and moves chip select only between whole half periods. It keeps the deliberate timeout gaps well above or well below the programmed limit, so no check depends on the exact boundary cycle.

// File: rtl/spib_pkg.sv
package spib_pkg;

    // Shared widths of the serial word and the register bus.
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 16;
    localparam int OP_W     = 4;
    localparam int CNT_W    = 7;
    localparam int STEP     = 4;

    // Field positions inside the command word; the sequencer decodes these.
    localparam int ADDR_LSB = WORD_W - ADDR_W;
    localparam int OP_LSB   = ADDR_LSB - OP_W;
    localparam int INC_BIT  = OP_LSB - 1;
    localparam int CNT_LSB  = INC_BIT - CNT_W;

    localparam logic [OP_W-1:0] OP_READ  = 4'hA;
    localparam logic [OP_W-1:0] OP_WRITE = 4'hB;

    localparam int BIT_W    = $clog2(WORD_W);

    typedef enum logic [1:0] {
        PH_CMD   = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } spib_phase_t;

    // Live state of a burst in progress.
    typedef struct packed {
        logic [ADDR_W-1:0] next_addr;
        logic [ADDR_W-1:0] step;
        logic [CNT_W:0]    left;
    } spib_burst_t;

    // Number of data words a count field asks for; zero means one.
    function automatic logic [CNT_W:0] burst_len(input logic [CNT_W-1:0] cnt);
        return (cnt == '0) ? (CNT_W+1)'(1) : {1'b0, cnt};
    endfunction

endpackage

// File: rtl/spib_sync.sv
module spib_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/spib_shift.sv
module spib_shift
    import spib_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              abort,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_bit,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_word,
    output logic              word_valid,
    output logic [WORD_W-1:0] rx_word,
    output logic              miso
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] rx_sr;
    logic [WORD_W-1:0] tx_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            word_valid <= 1'b0;
            rx_word    <= '0;
        end else if (!active || abort) begin
            bit_cnt    <= '0;
            tx_sr      <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (sclk_rise) begin
                rx_sr <= {rx_sr[WORD_W-3:0], mosi_bit};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt    <= '0;
                    word_valid <= 1'b1;
                    rx_word    <= {rx_sr, mosi_bit};
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end
            // Transmit side: a fresh load wins, a completed word empties the
            // register, otherwise a falling edge inside a word advances it.
            if (tx_load) begin
                tx_sr <= tx_word;
            end else if (sclk_rise && bit_cnt == LAST_BIT) begin
                tx_sr <= '0;
            end else if (sclk_fall && bit_cnt != '0) begin
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sr[WORD_W-1];

endmodule

// File: rtl/spib_seq.sv
module spib_seq
    import spib_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              sclk_rise,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [TO_W-1:0]   timeout_lim,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              abort,
    output logic              tx_load,
    output logic [WORD_W-1:0] tx_word,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_rd
);

    spib_phase_t       phase;
    spib_burst_t       burst;
    logic              rd_capt;
    logic [TO_W-1:0]   idle_cnt;

    logic [ADDR_W-1:0] cmd_addr;
    logic [OP_W-1:0]   cmd_op;
    logic [ADDR_W-1:0] cmd_step;
    logic [CNT_W:0]    cmd_len;

    always_comb begin
        cmd_addr = rx_word[ADDR_LSB +: ADDR_W];
        cmd_op   = rx_word[OP_LSB +: OP_W];
        cmd_step = rx_word[INC_BIT] ? ADDR_W'(STEP) : '0;
        cmd_len  = burst_len(rx_word[CNT_LSB +: CNT_W]);
    end

    assign abort   = active && (phase != PH_CMD) && (timeout_lim != '0)
                     && (idle_cnt >= timeout_lim);
    assign tx_load = rd_capt;
    assign tx_word = bus_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            burst     <= '0;
            rd_capt   <= 1'b0;
            idle_cnt  <= '0;
            bus_addr  <= '0;
            bus_wr    <= 1'b0;
            bus_wdata <= '0;
            bus_rd    <= 1'b0;
        end else begin
            bus_wr  <= 1'b0;
            bus_rd  <= 1'b0;
            rd_capt <= bus_rd && active && !abort;

            if (phase == PH_CMD || sclk_rise || !active) begin
                idle_cnt <= '0;
            end else if (idle_cnt < timeout_lim) begin
                idle_cnt <= idle_cnt + TO_W'(1);
            end

            if (!active || abort) begin
                phase      <= PH_CMD;
                burst.left <= '0;
            end else if (word_valid) begin
                unique case (phase)
                    PH_CMD: begin
                        burst.step <= cmd_step;
                        burst.left <= cmd_len;
                        if (cmd_op == OP_READ) begin
                            phase           <= PH_READ;
                            bus_rd          <= 1'b1;
                            bus_addr        <= cmd_addr;
                            burst.next_addr <= cmd_addr + cmd_step;
                        end else if (cmd_op == OP_WRITE) begin
                            phase           <= PH_WRITE;
                            burst.next_addr <= cmd_addr;
                        end
                    end
                    PH_READ: begin
                        if (burst.left == (CNT_W+1)'(1)) begin
                            phase <= PH_CMD;
                        end else begin
                            burst.left      <= burst.left - (CNT_W+1)'(1);
                            bus_rd          <= 1'b1;
                            bus_addr        <= burst.next_addr;
                            burst.next_addr <= burst.next_addr + burst.step;
                        end
                    end
                    PH_WRITE: begin
                        bus_wr          <= 1'b1;
                        bus_addr        <= burst.next_addr;
                        bus_wdata       <= rx_word;
                        burst.next_addr <= burst.next_addr + burst.step;
                        if (burst.left == (CNT_W+1)'(1)) begin
                            phase <= PH_CMD;
                        end else begin
                            burst.left <= burst.left - (CNT_W+1)'(1);
                        end
                    end
                    default: phase <= PH_CMD;
                endcase
            end
        end
    end

endmodule

// File: rtl/spib_bridge.sv
module spib_bridge
    import spib_pkg::*;
#(
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [TO_W-1:0]   burst_timeout,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              bus_rd,
    input  logic [WORD_W-1:0] bus_rdata
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0]  pins_s;
    logic              sclk_q;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_act;
    logic              abort;
    logic              tx_load;
    logic [WORD_W-1:0] tx_word;
    logic              word_valid;
    logic [WORD_W-1:0] rx_word;

    spib_sync #(
        .WIDTH   (PIN_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_cs_n, spi_sclk, spi_mosi}),
        .dout (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= pins_s[1];
    end

    assign cs_act    = ~pins_s[2];
    assign sclk_rise =  pins_s[1] & ~sclk_q;
    assign sclk_fall = ~pins_s[1] &  sclk_q;

    spib_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .active     (cs_act),
        .abort      (abort),
        .sclk_rise  (sclk_rise),
        .sclk_fall  (sclk_fall),
        .mosi_bit   (pins_s[0]),
        .tx_load    (tx_load),
        .tx_word    (tx_word),
        .word_valid (word_valid),
        .rx_word    (rx_word),
        .miso       (spi_miso)
    );

    spib_seq #(
        .TO_W (TO_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .active      (cs_act),
        .sclk_rise   (sclk_rise),
        .word_valid  (word_valid),
        .rx_word     (rx_word),
        .timeout_lim (burst_timeout),
        .bus_rdata   (bus_rdata),
        .abort       (abort),
        .tx_load     (tx_load),
        .tx_word     (tx_word),
        .bus_addr    (bus_addr),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rd      (bus_rd)
    );

endmodule

// File: rtl/spib_bridge_chk.sv
module spib_bridge_chk (
    input logic clk,
    input logic rst,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic bus_wr,
    input logic bus_rd
);

    // R10
    rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R10
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr);

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> !bus_rd);

    // R8
    cs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> (!bus_wr && !bus_rd));

    // R8
    cs_miso_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> !spi_miso);

endmodule

bind spib_bridge spib_bridge_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .spi_cs_n (spi_cs_n),
    .spi_miso (spi_miso),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd)
);

// File: tb/spib_bridge_tb_top.sv
`timescale 1ns/1ps
module spib_bridge_tb_top;

    localparam int HALF = 10;
    localparam int TMO  = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] burst_timeout = 16'(TMO);
    logic [15:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [31:0] bus_rdata = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] mem    [64];
    logic [31:0] shadow [64];
    logic [47:0] exp_wr_q [$];
    logic [15:0] exp_rd_q [$];

    always #2.5 clk = ~clk;

    spib_bridge dut_i (
        .clk           (clk),
        .rst           (rst),
        .spi_sclk      (spi_sclk),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .burst_timeout (burst_timeout),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rd        (bus_rd),
        .bus_rdata     (bus_rdata)
    );

    // Register bus slave model: read data one cycle after the strobe.
    always @(posedge clk) begin
        if (bus_wr) mem[bus_addr[7:2]] <= bus_wdata;
        if (bus_rd) bus_rdata <= mem[bus_addr[7:2]];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected bus accesses as they appear.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (bus_wr) begin
                if (exp_wr_q.size() == 0)
                    check(0, "R2", "unexpected write", {bus_addr, bus_wdata}, '0);
                else begin
                    logic [47:0] e;
                    e = exp_wr_q.pop_front();
                    check({bus_addr, bus_wdata} == e, "R2/R3", "write access",
                          {bus_addr, bus_wdata}, e);
                end
            end
            if (bus_rd) begin
                if (exp_rd_q.size() == 0)
                    check(0, "R4", "unexpected read", 48'(bus_addr), '0);
                else begin
                    logic [15:0] e;
                    e = exp_rd_q.pop_front();
                    check(bus_addr == e, "R4/R3", "read address",
                          48'(bus_addr), 48'(e));
                end
            end
        end
    end

    task automatic half_wait();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [31:0] tx, input int nbits,
                            output logic [31:0] rx);
        rx = '0;
        for (int i = 31; i > 31 - nbits; i--) begin
            spi_mosi = tx[i];
            half_wait();
            spi_sclk = 1'b1;
            rx[i] = spi_miso;
            half_wait();
            spi_sclk = 1'b0;
        end
    endtask

    task automatic spi_word(input logic [31:0] tx, output logic [31:0] rx);
        spi_bits(tx, 32, rx);
    endtask

    task automatic cs_on();
        spi_cs_n = 1'b0;
        half_wait();
    endtask

    task automatic cs_off();
        half_wait();
        spi_cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [31:0] mk_cmd(input logic [15:0] a, input logic [3:0] op,
                                           input bit inc, input int cnt);
        return {a, op, inc, 7'(cnt), 4'h9};
    endfunction

    function automatic int n_words(input int cnt);
        return (cnt == 0) ? 1 : cnt;
    endfunction

    task automatic burst_write(input logic [15:0] a, input bit inc, input int cnt,
                               input int seed);
        logic [31:0] rx;
        logic [15:0] ad;
        logic [31:0] d;
        spi_word(mk_cmd(a, 4'hB, inc, cnt), rx);
        for (int k = 0; k < n_words(cnt); k++) begin
            ad = inc ? 16'(a + 16'(4 * k)) : a;
            d  = 32'hC0DE_0000 ^ (seed << 8) ^ k;
            exp_wr_q.push_back({ad, d});
            shadow[ad[7:2]] = d;
            spi_word(d, rx);
        end
    endtask

    task automatic burst_read(input logic [15:0] a, input bit inc, input int cnt,
                              input string req);
        logic [31:0] rx;
        logic [15:0] ad;
        exp_rd_q.push_back(a);
        spi_word(mk_cmd(a, 4'hA, inc, cnt), rx);
        for (int k = 0; k < n_words(cnt); k++) begin
            ad = inc ? 16'(a + 16'(4 * k)) : a;
            if (k + 1 < n_words(cnt))
                exp_rd_q.push_back(inc ? 16'(a + 16'(4 * (k + 1))) : a);
            spi_word(32'hFFFF_FFFF, rx);
            check(rx == shadow[ad[7:2]], req, "read word on MISO",
                  48'(rx), 48'(shadow[ad[7:2]]));
        end
    endtask

    task automatic queues_empty(input string req);
        repeat (12) @(negedge clk);
        check(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, req,
              "pending bus accesses",
              48'(exp_wr_q.size() + exp_rd_q.size()), '0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]    = 32'h5EED_0000 | 32'(i * 7);
            shadow[i] = 32'h5EED_0000 | 32'(i * 7);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            check(0, "WD", "watchdog expired", '0, '0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rx;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        check(spi_miso == 1'b0 && bus_wr == 1'b0 && bus_rd == 1'b0, "R9",
              "outputs after reset", {45'b0, spi_miso, bus_wr, bus_rd}, '0);

        // R2 R3 stepped write burst, then R1 R4 stepped read back
        cs_on();
        burst_write(16'h0010, 1'b1, 3, 1);
        burst_read(16'h0010, 1'b1, 4, "R4");
        cs_off();
        queues_empty("R2");

        // R3 fixed-address write and read
        cs_on();
        burst_write(16'h0020, 1'b0, 2, 2);
        burst_read(16'h0020, 1'b0, 2, "R3");
        cs_off();
        queues_empty("R3");

        // R5 count zero: one word, then next word is a command
        cs_on();
        burst_write(16'h0030, 1'b1, 0, 3);
        burst_read(16'h0030, 1'b1, 0, "R5");
        burst_read(16'h0014, 1'b1, 1, "R5");
        cs_off();
        queues_empty("R5");

        // R6 unknown operation code
        cs_on();
        spi_word(mk_cmd(16'h0040, 4'h3, 1'b1, 2), rx);
        burst_read(16'h0018, 1'b0, 1, "R6");
        cs_off();
        queues_empty("R6");

        // R7 short gap keeps the burst alive
        cs_on();
        begin
            logic [31:0] d0, d1;
            d0 = 32'h1111_2222; d1 = 32'h3333_4444;
            spi_word(mk_cmd(16'h0050, 4'hB, 1'b1, 2), rx);
            exp_wr_q.push_back({16'h0050, d0}); shadow[20] = d0;
            spi_word(d0, rx);
            repeat (TMO / 2) @(negedge clk);
            exp_wr_q.push_back({16'h0054, d1}); shadow[21] = d1;
            spi_word(d1, rx);
        end
        cs_off();
        queues_empty("R7");

        // R7 long gap abandons the burst
        cs_on();
        begin
            logic [31:0] d0;
            d0 = 32'hABCD_0001;
            spi_word(mk_cmd(16'h0060, 4'hB, 1'b1, 3), rx);
            exp_wr_q.push_back({16'h0060, d0}); shadow[24] = d0;
            spi_word(d0, rx);
            repeat (2 * TMO) @(negedge clk);
            burst_read(16'h0050, 1'b1, 2, "R7");
        end
        cs_off();
        queues_empty("R7");

        // R8 chip select release mid-burst and mid-word
        cs_on();
        begin
            logic [31:0] d0;
            d0 = 32'h7777_0000;
            spi_word(mk_cmd(16'h0070, 4'hB, 1'b1, 4), rx);
            exp_wr_q.push_back({16'h0070, d0}); shadow[28] = d0;
            spi_word(d0, rx);
        end
        cs_off();
        check(spi_miso == 1'b0, "R8", "MISO while deselected", 48'(spi_miso), '0);
        cs_on();
        spi_bits(32'hFFFF_FFFF, 10, rx);
        cs_off();
        cs_on();
        burst_read(16'h0070, 1'b0, 1, "R8");
        burst_read(16'h0010, 1'b1, 3, "R8");
        cs_off();
        check(spi_miso == 1'b0, "R8", "MISO after frame", 48'(spi_miso), '0);
        queues_empty("R8");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule